// File: doc/BRIEF.md
# PIO Command and Data Queue

This block is the front end between a register bus and a serial-bus master engine. Software writes command words into a command queue and outgoing data words into a transmit queue. The engine receives one command at a time, and only while the run control bit is set. Bytes that the engine receives are packed into words and placed in a read queue, which software drains through one register.

Software follows progress through a status register. The register shows how many command words are still waiting, whether the read queue is empty, and whether any write was lost to a full queue. A one-cycle completion pulse fires when the engine finishes a command and no further command is waiting. A transfer is run as follows: queue the commands and data, set the run bit, wait for the completion pulse, collect the received words, then clear the run bit.

Register offsets: control at 0x00, with a set alias at 0x04 and a clear alias at 0x08. Status at 0x10. Command push at 0x20. Transmit-data push at 0x30. Read-queue pop at 0x40.

Top module: `pio_cmd_queue`

## Requirements
- R1: After reset the control register reads 0, status reads 0x2000 (read queue empty, no commands pending, no overflow), and no command is presented to the engine.
- R2: Control bit 5 is run and bit 2 is queue mode (driven on `q_mode`). A write to 0x00 loads both bits, a write to 0x04 sets the bits that are 1 in the data, and a write to 0x08 clears them.
- R3: The command queue holds 16 words. Status bits 4:0 give the number of command words pushed through 0x20 that the engine has not yet taken.
- R4: A command is taken from the queue, oldest first, only when run is set and no command is active. It stays on `eng_cmd_word` with `eng_cmd_valid` high until `eng_done`. The next command is taken at the earliest one cycle after that.
- R5: Clearing run does not stop the active command, but no further command is taken until run is set again.
- R6: `queue_done` pulses for one cycle, in the cycle after `eng_done`, when the pending count was zero at that `eng_done`.
- R7: The transmit queue presents its oldest word on `eng_tx_data`, with `eng_tx_valid` high while it is not empty. `eng_tx_pop` removes that word.
- R8: Received bytes fill a read word starting at bits 7:0 and moving upward. The word is pushed when its fourth byte arrives.
- R9: A byte flagged with `eng_rx_last` pushes the partly filled word at once. Its unfilled upper bytes are zero, and the next byte starts a fresh word.
- R10: Status bit 13 is high while the read queue is empty. A read of 0x40 returns the oldest word and removes it. A read of 0x40 when the queue is empty returns zero.
- R11: A push into a full queue (command, transmit or read) is dropped and sets the sticky overflow flag, status bit 15. Writing 0x10 with bit 15 set clears the flag.
- R12: When a word is pushed into a queue and taken from it in the same cycle, both actions take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops the read queue at 0x40) |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| q_mode | output | 1 | Queue-mode control bit |
| eng_cmd_valid | output | 1 | Active command present |
| eng_cmd_word | output | 32 | Active command word |
| eng_done | input | 1 | Engine finished the active command |
| eng_tx_valid | output | 1 | Transmit queue not empty |
| eng_tx_data | output | 32 | Oldest transmit word |
| eng_tx_pop | input | 1 | Engine consumes the transmit word |
| eng_rx_byte | input | 8 | Received byte |
| eng_rx_strobe | input | 1 | Received byte valid |
| eng_rx_last | input | 1 | This byte ends the receive command |
| queue_done | output | 1 | Last queued command completed |

## Verification
Two actions can fall in the same cycle. The engine's packer can complete a read word on the same edge that software pops the read queue. To provoke this, the fourth byte of a new word is strobed on the same cycle as a read of 0x40, while the queue holds one earlier word. The result is correct if the read returns the earlier word and the newer word is left alone as the only entry: status bit 13 stays low, one more read returns the new word, and the read after that returns zero.

// File: rtl/pio_cmd_queue.sv
module pio_cmd_queue #(
  parameter int DEPTH = 16,
  parameter int DW    = 32,
  parameter int AW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          q_mode,
  output logic          eng_cmd_valid,
  output logic [DW-1:0] eng_cmd_word,
  input  logic          eng_done,
  output logic          eng_tx_valid,
  output logic [DW-1:0] eng_tx_data,
  input  logic          eng_tx_pop,
  input  logic [7:0]    eng_rx_byte,
  input  logic          eng_rx_strobe,
  input  logic          eng_rx_last,
  output logic          queue_done
);
  // DEPTH must be a power of two; pointers wrap naturally.
  localparam int PW    = $clog2(DEPTH);
  localparam int CW    = PW + 1;
  localparam int LANES = DW / 8;
  localparam int LW    = $clog2(LANES);
  localparam logic [AW-1:0] A_CTRL = AW'(8'h00);
  localparam logic [AW-1:0] A_SET  = AW'(8'h04);
  localparam logic [AW-1:0] A_CLR  = AW'(8'h08);
  localparam logic [AW-1:0] A_STAT = AW'(8'h10);
  localparam logic [AW-1:0] A_CMD  = AW'(8'h20);
  localparam logic [AW-1:0] A_TX   = AW'(8'h30);
  localparam logic [AW-1:0] A_RX   = AW'(8'h40);

  logic run_q, mode_q, busy_q, ovf_q, done_q;
  logic [DW-1:0] act_q, rx_acc;
  logic [LW-1:0] lane;
  logic [DW-1:0] cmd_mem [DEPTH];
  logic [DW-1:0] tx_mem  [DEPTH];
  logic [DW-1:0] rx_mem  [DEPTH];
  logic [PW-1:0] cmd_wp, cmd_rp, tx_wp, tx_rp, rx_wp, rx_rp;
  logic [CW-1:0] cmd_cnt, tx_cnt, rx_cnt;

  wire cmd_full = cmd_cnt == CW'(DEPTH);
  wire tx_full  = tx_cnt  == CW'(DEPTH);
  wire rx_full  = rx_cnt  == CW'(DEPTH);
  wire cmd_wr   = reg_wr && reg_addr == A_CMD;
  wire tx_wr    = reg_wr && reg_addr == A_TX;
  wire cmd_push = cmd_wr && !cmd_full;
  wire cmd_pop  = run_q && !busy_q && cmd_cnt != '0;
  wire tx_push  = tx_wr && !tx_full;
  wire tx_pop   = eng_tx_pop && tx_cnt != '0;
  wire rx_word_end = eng_rx_strobe && (lane == LW'(LANES-1) || eng_rx_last);
  wire rx_push  = rx_word_end && !rx_full;
  wire rx_pop   = reg_rd && reg_addr == A_RX && rx_cnt != '0;
  wire ovf_set  = (cmd_wr && cmd_full) || (tx_wr && tx_full) || (rx_word_end && rx_full);
  wire [DW-1:0] rx_word = rx_acc | (DW'(eng_rx_byte) << {lane, 3'b000});

  assign q_mode        = mode_q;
  assign eng_cmd_valid = busy_q;
  assign eng_cmd_word  = act_q;
  assign eng_tx_valid  = tx_cnt != '0;
  assign eng_tx_data   = tx_mem[tx_rp];
  assign queue_done    = done_q;

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_CTRL, A_SET, A_CLR: begin
        reg_rdata[5] = run_q;
        reg_rdata[2] = mode_q;
      end
      A_STAT: begin
        reg_rdata[CW-1:0] = cmd_cnt;
        reg_rdata[13]     = rx_cnt == '0;
        reg_rdata[15]     = ovf_q;
      end
      A_RX:    reg_rdata = (rx_cnt != '0) ? rx_mem[rx_rp] : '0;
      default: reg_rdata = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (cmd_push) cmd_mem[cmd_wp] <= reg_wdata;
    if (tx_push)  tx_mem[tx_wp]   <= reg_wdata;
    if (rx_push)  rx_mem[rx_wp]   <= rx_word;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q <= 1'b0; mode_q <= 1'b0; busy_q <= 1'b0; ovf_q <= 1'b0; done_q <= 1'b0;
      act_q <= '0; rx_acc <= '0; lane <= '0;
      cmd_wp <= '0; cmd_rp <= '0; cmd_cnt <= '0;
      tx_wp  <= '0; tx_rp  <= '0; tx_cnt  <= '0;
      rx_wp  <= '0; rx_rp  <= '0; rx_cnt  <= '0;
    end else begin
      if (reg_wr && reg_addr == A_CTRL) begin
        run_q <= reg_wdata[5]; mode_q <= reg_wdata[2];
      end else if (reg_wr && reg_addr == A_SET) begin
        run_q <= run_q | reg_wdata[5]; mode_q <= mode_q | reg_wdata[2];
      end else if (reg_wr && reg_addr == A_CLR) begin
        run_q <= run_q & ~reg_wdata[5]; mode_q <= mode_q & ~reg_wdata[2];
      end

      if (ovf_set) ovf_q <= 1'b1;
      else if (reg_wr && reg_addr == A_STAT && reg_wdata[15]) ovf_q <= 1'b0;

      if (cmd_pop) begin
        act_q  <= cmd_mem[cmd_rp];
        busy_q <= 1'b1;
      end else if (eng_done) begin
        busy_q <= 1'b0;
      end
      done_q <= busy_q && eng_done && cmd_cnt == '0;

      if (eng_rx_strobe) begin
        rx_acc <= rx_word_end ? '0 : rx_word;
        lane   <= rx_word_end ? '0 : lane + 1'b1;
      end

      if (cmd_push) cmd_wp <= cmd_wp + 1'b1;
      if (cmd_pop)  cmd_rp <= cmd_rp + 1'b1;
      cmd_cnt <= cmd_cnt + CW'(cmd_push) - CW'(cmd_pop);
      if (tx_push) tx_wp <= tx_wp + 1'b1;
      if (tx_pop)  tx_rp <= tx_rp + 1'b1;
      tx_cnt <= tx_cnt + CW'(tx_push) - CW'(tx_pop);
      if (rx_push) rx_wp <= rx_wp + 1'b1;
      if (rx_pop)  rx_rp <= rx_rp + 1'b1;
      rx_cnt <= rx_cnt + CW'(rx_push) - CW'(rx_pop);
    end
  end

  p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_cnt <= CW'(DEPTH) && tx_cnt <= CW'(DEPTH) && rx_cnt <= CW'(DEPTH));
  p_fetch_run_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(eng_cmd_valid) |-> $past(run_q));
  p_hold_cmd_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_cmd_valid && !eng_done) |=> (eng_cmd_valid && $stable(eng_cmd_word)));
  p_done_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    queue_done |-> !eng_cmd_valid);
  p_overflow_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && cmd_full) |=> (ovf_q && $stable(cmd_cnt) || $past(cmd_pop)));
  p_empty_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == A_RX && rx_cnt == '0) |-> reg_rdata == '0);
endmodule

// File: tb/pio_cmd_queue_tb_top.sv
module pio_cmd_queue_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 0, reg_rd = 0;
  logic [7:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic q_mode, eng_cmd_valid, eng_tx_valid, queue_done;
  logic [31:0] eng_cmd_word, eng_tx_data;
  logic eng_done = 0, eng_tx_pop = 0, eng_rx_strobe = 0, eng_rx_last = 0;
  logic [7:0] eng_rx_byte = 0;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  pio_cmd_queue dut_i (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_rd = 1; #1 d = reg_rdata;
    @(negedge clk); reg_rd = 0;
  endtask

  task automatic done_pulse();
    @(negedge clk); eng_done = 1;
    @(negedge clk); eng_done = 0;
  endtask

  task automatic rx_byte(logic [7:0] b, logic last);
    @(negedge clk); eng_rx_byte = b; eng_rx_last = last; eng_rx_strobe = 1;
    @(negedge clk); eng_rx_strobe = 0; eng_rx_last = 0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(8'h00, v); chk("R1 ctrl", v, 0);
    rd(8'h10, v); chk("R1 status", v, 32'h2000);
    chk("R1 cmd_valid", eng_cmd_valid, 0);
  endtask

  task automatic t_ctrl();
    logic [31:0] v;
    wr(8'h00, 32'h24); rd(8'h04, v); chk("R2 load", v, 32'h24);
    wr(8'h08, 32'h20); rd(8'h00, v); chk("R2 clear run", v, 32'h04);
    chk("R2 q_mode", q_mode, 1);
    wr(8'h04, 32'h20); rd(8'h08, v); chk("R2 set run", v, 32'h24);
    wr(8'h08, 32'h24); rd(8'h00, v); chk("R2 clear both", v, 0);
  endtask

  task automatic t_cmd();
    logic [31:0] v;
    wr(8'h20, 32'hA0); wr(8'h20, 32'hB1); wr(8'h20, 32'hC2);
    rd(8'h10, v); chk("R3 pending count", v[4:0], 3);
    chk("R4 no fetch without run", eng_cmd_valid, 0);
    wr(8'h04, 32'h20);
    @(negedge clk);
    chk("R4 first valid", eng_cmd_valid, 1); chk("R4 first word", eng_cmd_word, 32'hA0);
    rd(8'h10, v); chk("R3 count after fetch", v[4:0], 2);
    repeat (3) @(negedge clk);
    chk("R4 held until done", eng_cmd_word, 32'hA0);
    done_pulse();
    chk("R6 no done with pending", queue_done, 0);
    chk("R4 idle one cycle", eng_cmd_valid, 0);
    @(negedge clk); chk("R4 second word", eng_cmd_word, 32'hB1);
    wr(8'h08, 32'h20);
    chk("R5 active continues", eng_cmd_valid, 1);
    done_pulse();
    repeat (3) @(negedge clk);
    chk("R5 no fetch after clear", eng_cmd_valid, 0);
    rd(8'h10, v); chk("R5 count held", v[4:0], 1);
    wr(8'h04, 32'h20);
    @(negedge clk); chk("R4 third word", eng_cmd_word, 32'hC2);
    done_pulse();
    chk("R6 done pulse", queue_done, 1);
    @(negedge clk); chk("R6 pulse one cycle", queue_done, 0);
    wr(8'h08, 32'h20);
  endtask

  task automatic t_tx();
    chk("R7 empty", eng_tx_valid, 0);
    wr(8'h30, 32'h1111); wr(8'h30, 32'h2222); wr(8'h30, 32'h3333);
    chk("R7 valid", eng_tx_valid, 1); chk("R7 head", eng_tx_data, 32'h1111);
    @(negedge clk); eng_tx_pop = 1; @(negedge clk); eng_tx_pop = 0;
    chk("R7 next", eng_tx_data, 32'h2222);
    repeat (2) begin @(negedge clk); eng_tx_pop = 1; @(negedge clk); eng_tx_pop = 0; end
    chk("R7 drained", eng_tx_valid, 0);
  endtask

  task automatic t_rx();
    logic [31:0] v;
    rx_byte(8'h11, 0); rx_byte(8'h22, 0); rx_byte(8'h33, 0); rx_byte(8'h44, 0);
    rx_byte(8'h55, 0); rx_byte(8'h66, 1);
    rd(8'h10, v); chk("R10 not empty", v[13], 0);
    rd(8'h40, v); chk("R8 packed word", v, 32'h44332211);
    rd(8'h40, v); chk("R9 partial word", v, 32'h00006655);
    rd(8'h40, v); chk("R10 empty read zero", v, 0);
    rd(8'h10, v); chk("R10 empty flag", v[13], 1);
  endtask

  task automatic t_same();
    logic [31:0] v;
    rx_byte(8'hAA, 0); rx_byte(8'hBB, 0); rx_byte(8'hCC, 0); rx_byte(8'hDD, 0);
    rx_byte(8'h01, 0); rx_byte(8'h02, 0); rx_byte(8'h03, 0);
    @(negedge clk);
    eng_rx_byte = 8'h04; eng_rx_strobe = 1; reg_addr = 8'h40; reg_rd = 1;
    #1 v = reg_rdata;
    chk("R12 pop old word", v, 32'hDDCCBBAA);
    @(negedge clk); eng_rx_strobe = 0; reg_rd = 0;
    rd(8'h10, v); chk("R12 one word left", v[13], 0);
    rd(8'h40, v); chk("R12 new word kept", v, 32'h04030201);
    rd(8'h40, v); chk("R12 then empty", v, 0);
  endtask

  task automatic t_ovf();
    logic [31:0] v;
    for (int i = 0; i < 17; i++) wr(8'h20, 32'h100 + i);
    rd(8'h10, v); chk("R11 count full", v[4:0], 16); chk("R11 flag set", v[15], 1);
    wr(8'h10, 32'h8000);
    rd(8'h10, v); chk("R11 flag cleared", v[15], 0);
    wr(8'h04, 32'h20);
    for (int i = 0; i < 16; i++) begin
      for (int k = 0; k < 5 && !eng_cmd_valid; k++) @(negedge clk);
      chk("R11 kept order", eng_cmd_word, 32'h100 + i);
      done_pulse();
    end
    chk("R11 extra dropped", queue_done, 1);
    repeat (2) @(negedge clk);
    chk("R11 no extra command", eng_cmd_valid, 0);
    wr(8'h08, 32'h20);
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_ctrl();
    t_cmd();
    t_tx();
    t_rx();
    t_same();
    t_ovf();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule